// File: doc/BRIEF.md
# Video RAM byte-port with auto-increment

This block lets an 8-bit register bus fill a memory of 16-bit words. A 16-bit word address is loaded one byte at a time through two address registers. Two data registers then write the low and the high half of the word that the address points to. Each half sits in its own byte-wide bank, and a data write changes only that bank.

After a data write the word address steps by one. A bit in the control register decides which half triggers the step: the low-byte write or the high-byte write. Software that sends the high byte first clears the bit. Software that sends the low byte first sets it. In both cases the word is complete before the address moves on, so a block transfer can stream a whole sequence of words without reloading the address.

A separate synchronous read port returns a full word one clock after it is requested. The memory is two inferable byte-wide arrays indexed by the low `MEM_AW` bits of the word address. The current word address and the control register are outputs taken straight from their registers.

Top module: `vram_byte_port`

## Requirements
- R1: While `rst` is high at a clock edge, the word address and the control register both become 0x0000 / 0x00 and appear so on `word_addr_o` and `ctrl_o` after that edge.
- R2: A write with `reg_sel` = 1 loads bits 7:0 of the word address from `reg_wdata`, and `reg_sel` = 2 loads bits 15:8; the other address byte is kept. `reg_sel` = 0 loads the control register.
- R3: With control bit 7 at 0, a low-data write (`reg_sel` = 3) increments the word address by one after the write, and a high-data write (`reg_sel` = 4) leaves the address unchanged.
- R4: With control bit 7 at 1, a high-data write increments the word address by one after the write, and a low-data write leaves the address unchanged.
- R5: A low-data write stores `reg_wdata` into bits 7:0 of the word at the current address (before any increment), and a high-data write stores it into bits 15:8; the other half of that word is left unchanged.
- R6: The word address wraps from 0xFFFF to 0x0000 on an increment.
- R7: When `rd_en` is high at an edge, `rd_data` shows the word at `rd_addr` (modulo 2^`MEM_AW`) after that edge, with the contents from before any write made at the same edge. While `rd_en` is low, `rd_data` holds its value.
- R8: Writes with `reg_sel` values 5, 6 or 7 change neither the address, the control register nor the memory.
- R9: With control bit 7 at 1, 0x400 word writes in low-then-high order starting at address 0x2000 leave the address at 0x2400, and every word reads back its written value. The high-then-low order with bit 7 at 0 does the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wdata | input | 8 | Register write byte |
| rd_en | input | 1 | Read port enable |
| rd_addr | input | 16 | Read port word address |
| rd_data | output | 16 | Registered read word, high byte in 15:8 |
| word_addr_o | output | 16 | Current word address |
| ctrl_o | output | 8 | Control register; bit 7 selects the increment trigger |

## Verification
A byte write into a word and a read of that same word through the read port can happen at the same clock edge. The bench causes this by raising `rd_en` for a word in the same cycle that it writes that word's high byte. It then expects the word as it was before the write, and it expects the merged word on a second read. A data write and its address increment also fall on one edge: right after each data write the bench checks the address it expects, and through the read port it checks that the byte went to the address from before the increment.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int SEL_W   = 3;
  localparam int INC_BIT = 7;

  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDR_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATA_LO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA_HI = 3'd4;
endpackage

// File: rtl/vp_ctrl.sv
module vp_ctrl
  import vram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [1:0]        half_we
);
  logic [ADDR_W-1:0] addr_nxt;
  logic              hit_lo;
  logic              hit_hi;
  logic              step;

  assign hit_lo   = reg_we && (reg_sel == SEL_DATA_LO);
  assign hit_hi   = reg_we && (reg_sel == SEL_DATA_HI);
  assign half_we  = {hit_hi, hit_lo};
  assign step     = ctrl_q[INC_BIT] ? hit_hi : hit_lo;
  assign addr_nxt = addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_CTRL:    ctrl_q <= reg_wdata;
        SEL_ADDR_LO: addr_q[BYTE_W-1:0] <= reg_wdata;
        SEL_ADDR_HI: addr_q[ADDR_W-1:BYTE_W] <= reg_wdata;
        SEL_DATA_LO,
        SEL_DATA_HI: if (step) addr_q <= addr_nxt;
        default:     ;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (addr_q == '0 && ctrl_q == '0));

  a_r2_addr_lo_load: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == SEL_ADDR_LO) |=>
      (addr_q[BYTE_W-1:0] == $past(reg_wdata) &&
       addr_q[ADDR_W-1:BYTE_W] == $past(addr_q[ADDR_W-1:BYTE_W])));

  a_r2_addr_hi_load: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == SEL_ADDR_HI) |=>
      (addr_q[ADDR_W-1:BYTE_W] == $past(reg_wdata) &&
       addr_q[BYTE_W-1:0] == $past(addr_q[BYTE_W-1:0])));

  a_r3_low_steps: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && !ctrl_q[INC_BIT]) |=> (addr_q == $past(addr_nxt)));

  a_r3_high_holds: assert property (@(posedge clk) disable iff (rst)
    (hit_hi && !ctrl_q[INC_BIT]) |=> $stable(addr_q));

  a_r4_high_steps: assert property (@(posedge clk) disable iff (rst)
    (hit_hi && ctrl_q[INC_BIT]) |=> (addr_q == $past(addr_nxt)));

  a_r4_low_holds: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && ctrl_q[INC_BIT]) |=> $stable(addr_q));

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && addr_q == {ADDR_W{1'b1}}) |=> (addr_q == '0));

  a_r8_unused_sel: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel > SEL_DATA_HI) |=> ($stable(addr_q) && $stable(ctrl_q)));

  a_r5_one_half: assert property (@(posedge clk) disable iff (rst)
    $onehot0(half_we));
endmodule

// File: rtl/vp_bank.sv
module vp_bank #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/vram_byte_port.sv
module vram_byte_port
  import vram_port_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic [1:0]        half_we;
  logic [BYTE_W-1:0] half_rd [2];

  vp_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .addr_q    (addr_q),
    .ctrl_q    (ctrl_q),
    .half_we   (half_we)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    vp_bank #(.AW(MEM_AW), .DW(BYTE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (half_we[g]),
      .waddr (addr_q[MEM_AW-1:0]),
      .wdata (reg_wdata),
      .re    (rd_en),
      .raddr (rd_addr[MEM_AW-1:0]),
      .rdata (half_rd[g])
    );
  end

  assign rd_data     = {half_rd[1], half_rd[0]};
  assign word_addr_o = addr_q;
  assign ctrl_o      = ctrl_q;

  a_r8_no_bank_write: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel > SEL_DATA_HI) |-> (half_we == 2'b00));
endmodule

// File: tb/vram_byte_port_bench.sv
`timescale 1ns/1ps
module vram_byte_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] word_addr_o;
  logic [7:0]  ctrl_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vram_byte_port u_vram_byte_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .word_addr_o(word_addr_o), .ctrl_o(ctrl_o)
  );

  // {sel, data, expected address after the write}
  localparam logic [26:0] VEC [12] = '{
    {3'd0, 8'h00, 16'h0000},
    {3'd1, 8'h34, 16'h0034},
    {3'd2, 8'h12, 16'h1234},
    {3'd4, 8'hAB, 16'h1234},
    {3'd3, 8'hCD, 16'h1235},
    {3'd0, 8'h80, 16'h1235},
    {3'd3, 8'h11, 16'h1235},
    {3'd4, 8'h22, 16'h1236},
    {3'd0, 8'h7F, 16'h1236},
    {3'd3, 8'h33, 16'h1237},
    {3'd5, 8'hFF, 16'h1237},
    {3'd7, 8'h00, 16'h1237}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(3'd1, a[7:0]);
    wr(3'd2, a[15:8]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 addr", word_addr_o, 16'h0000);
    check("R1 ctrl", {8'h00, ctrl_o}, 16'h0000);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R8
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][26:24], VEC[i][23:16]);
      check("R2/R3/R4/R8 table addr", word_addr_o, VEC[i][15:0]);
    end
    check("R2 ctrl load", {8'h00, ctrl_o}, 16'h007F);
    rd(16'h1234); check("R5 word 1234", rd_data, 16'hABCD);
    rd(16'h1235); check("R5 word 1235", rd_data, 16'h2211);

    // R5: single half rewrite keeps the other half
    wr(3'd0, 8'h80);
    set_addr(16'h0100);
    wr(3'd3, 8'h55); wr(3'd4, 8'h66);
    check("R4 addr after pair", word_addr_o, 16'h0101);
    set_addr(16'h0100);
    wr(3'd3, 8'h77);
    rd(16'h0100); check("R5 low only", rd_data, 16'h6677);

    // R8: unused selects leave memory untouched
    wr(3'd6, 8'hEE);
    rd(16'h0100); check("R8 memory kept", rd_data, 16'h6677);

    // R7: same-edge write and read return old contents
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h99;
    rd_en = 1'b1; rd_addr = 16'h0100;
    @(negedge clk);
    reg_we = 1'b0; rd_en = 1'b0;
    check("R7 read-first", rd_data, 16'h6677);
    repeat (3) @(negedge clk);
    check("R7 hold", rd_data, 16'h6677);
    rd(16'h0100); check("R7 merged", rd_data, 16'h9977);

    // R6: wrap on both triggers
    set_addr(16'hFFFF);
    wr(3'd4, 8'h01);
    check("R6 wrap high trigger", word_addr_o, 16'h0000);
    wr(3'd0, 8'h00);
    set_addr(16'hFFFF);
    wr(3'd3, 8'h02);
    check("R6 wrap low trigger", word_addr_o, 16'h0000);

    // R9: burst low-then-high, bit 7 set
    wr(3'd0, 8'h80);
    set_addr(16'h2000);
    for (int i = 0; i < 16'h400; i++) begin
      wr(3'd3, i[7:0]);
      wr(3'd4, i[15:8]);
    end
    check("R9 end addr", word_addr_o, 16'h2400);
    rd(16'h2000); check("R9 word 0", rd_data, 16'h0000);
    rd(16'h2155); check("R9 word 155", rd_data, 16'h0155);
    rd(16'h23FF); check("R9 word 3FF", rd_data, 16'h03FF);

    // R9: burst high-then-low, bit 7 clear
    wr(3'd0, 8'h00);
    set_addr(16'h2000);
    for (int i = 0; i < 16'h400; i++) begin
      wr(3'd4, 8'hC0 ^ i[15:8]);
      wr(3'd3, 8'h5A ^ i[7:0]);
    end
    check("R9 end addr reverse", word_addr_o, 16'h2400);
    rd(16'h2001); check("R9 reverse word 1", rd_data, 16'hC05B);
    rd(16'h22AA); check("R9 reverse word 2AA", rd_data, 16'hC2F0);

    // R1: reset mid-run
    wr(3'd0, 8'h80);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 addr after reset", word_addr_o, 16'h0000);
    check("R1 ctrl after reset", {8'h00, ctrl_o}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule